// File: doc/BRIEF.md
# Three-wire serial EEPROM target model

This block behaves as the device end of a three-wire serial EEPROM bus: a select line, a serial clock and one data line in each direction. It holds 128 bytes in on-chip RAM and can present them as 128 bytes or as 64 sixteen-bit words, as set by a mode pin. A host raises the select line, clocks in a start bit, a two-bit command and an address, and then either streams data out, supplies a word to store, or issues a control command. Control commands set or clear a write-enable latch and erase the whole memory.

All inputs are oversampled by the system clock through a synchronizer. Serial bits are taken on rising serial-clock edges. The serial clock's high and low phases must each last at least six system clock periods. Between commands the host must hold select low for at least 80 system clock periods, because an erase runs as a sweep over the RAM.

Top module: `mw_eeprom`

## Requirements
- R1: After reset `sdo` is 0 and the write-enable latch is clear, so a write sent straight after reset leaves memory unchanged.
- R2: While `sel` is high and no command has started, 0 bits on `sdi` are ignored; the first 1 sampled on a rising `sclk` edge is the start bit.
- R3: After the start bit come a 2-bit command code (MSB first) and then an address, MSB first: 7 bits (a byte address) when `wide`=0, 6 bits (a word address) when `wide`=1.
- R4: Code 10 is a read. On the rising edge that carries the last address bit, `sdo` is driven to a dummy 0. Each later rising edge then presents the next bit of the addressed unit, MSB first: 8 bits when `wide`=0, 16 bits when `wide`=1.
- R5: While `sel` stays high a read keeps streaming consecutive units, wrapping from the last unit of memory to unit 0.
- R6: Word n in 16-bit mode occupies byte 2n (its upper 8 bits) and byte 2n+1 (its lower 8 bits) in 8-bit mode.
- R7: Code 01 is a write. It is followed by 8 or 16 data bits, MSB first, and the addressed unit is updated after the last data bit.
- R8: Code 00 is a control command selected by the two most significant address bits: 11 sets the write-enable latch and 00 clears it.
- R9: Code 00 with upper address bits 10 sets every memory bit to 1. The erase completes within 64 system clock cycles.
- R10: A write or an erase sent while the write-enable latch is clear does not change memory.
- R11: Lowering `sel` at any point aborts the command without changing memory and returns `sdo` to 0.
- R12: Code 11, and code 00 with upper address bits 01, change neither memory nor the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wide | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |

## Verification
The hardest situations to reach from the pins are the gated ones: a write or erase refused because the latch is clear, and a command cut off partway. Neither produces any output, so the bench reads memory back afterwards to see the untouched contents. It also prepares states such as a latch set before a reset, an all-ones memory, and a read begun at the top address so that it crosses the wrap point. The byte-to-word layout is checked by writing in one organisation and reading in the other.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WDATA,
    ST_READ,
    ST_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    CODE_SYS   = 2'b00,
    CODE_WRITE = 2'b01,
    CODE_READ  = 2'b10,
    CODE_RSVD  = 2'b11
  } mw_code_e;

  localparam logic [1:0] SYS_LOCK  = 2'b00;
  localparam logic [1:0] SYS_FILL  = 2'b10;
  localparam logic [1:0] SYS_ARM   = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int WORDS = 64,
  parameter int LW    = 8,
  localparam int WA   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [WA-1:0] wr_addr,
  input  logic [1:0]    wr_lanes,
  input  logic [2*LW-1:0] wr_data,
  input  logic [WA-1:0] rd_addr,
  output logic [2*LW-1:0] rd_data,
  input  logic          erase_go,
  output logic          erasing
);

  logic [WA-1:0] sweep;
  logic [WA-1:0] port_addr;
  logic [1:0]    port_lanes;
  logic [2*LW-1:0] port_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      erasing <= 1'b0;
      sweep   <= '0;
    end else if (erase_go) begin
      erasing <= 1'b1;
      sweep   <= '0;
    end else if (erasing) begin
      sweep <= sweep + 1'b1;
      if (sweep == WA'(WORDS-1)) erasing <= 1'b0;
    end
  end

  always_comb begin
    if (erasing) begin
      port_addr  = sweep;
      port_lanes = 2'b11;
      port_data  = '1;
    end else begin
      port_addr  = wr_addr;
      port_lanes = wr_en ? wr_lanes : 2'b00;
      port_data  = wr_data;
    end
  end

  genvar l;
  generate
    for (l = 0; l < 2; l++) begin : g_lane
      logic [LW-1:0] ram [WORDS];
      always_ff @(posedge clk) begin
        if (port_lanes[l]) ram[port_addr] <= port_data[l*LW +: LW];
        rd_data[l*LW +: LW] <= ram[rd_addr];
      end
    end
  endgenerate

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int LW    = 8,
  parameter int BA    = 7,
  localparam int WA   = BA - 1,
  localparam int HW   = 2 + BA,
  localparam int CW   = $clog2(2*LW + HW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic            sk_rise,
  input  logic            din,
  input  logic            wide,
  output logic            wel,
  output logic            wr_en,
  output logic [WA-1:0]   wr_addr,
  output logic [1:0]      wr_lanes,
  output logic [2*LW-1:0] wr_data,
  output logic            erase_go,
  output logic [WA-1:0]   rd_addr,
  input  logic [2*LW-1:0] rd_data,
  output logic            dout
);

  localparam logic [CW-1:0] LAST_HDR_N = CW'(HW-1);
  localparam logic [CW-1:0] LAST_HDR_W = CW'(HW-2);
  localparam logic [CW-1:0] LAST_DAT_N = CW'(LW-1);
  localparam logic [CW-1:0] LAST_DAT_W = CW'(2*LW-1);

  mw_state_e       st;
  logic [HW-2:0]   hsr;
  logic [2*LW-1:0] wsr;
  logic [2*LW-1:0] osr;
  logic [CW-1:0]   cnt;
  logic [BA-1:0]   ptr;
  logic [1:0]      ld_pipe;

  logic [HW-1:0]   hdr_full;
  logic [HW-1:0]   hdr_al;
  mw_code_e        code;
  logic [1:0]      sys_sel;
  logic [BA-1:0]   hdr_ptr;
  logic            hdr_last;
  logic            dat_last;

  always_comb begin
    hdr_full = {hsr, din};
    hdr_al   = wide ? {hdr_full[HW-2:0], 1'b0} : hdr_full;
    code     = mw_code_e'(hdr_al[HW-1 -: 2]);
    sys_sel  = hdr_al[BA-1 -: 2];
    hdr_ptr  = wide ? {hdr_al[BA-1:1], 1'b0} : hdr_al[BA-1:0];
    hdr_last = (cnt == (wide ? LAST_HDR_W : LAST_HDR_N));
    dat_last = (cnt == (wide ? LAST_DAT_W : LAST_DAT_N));
  end

  assign rd_addr  = ptr[BA-1:1];
  assign wr_addr  = ptr[BA-1:1];
  assign wr_lanes = wide ? 2'b11 : (ptr[0] ? 2'b01 : 2'b10);
  assign wr_data  = wide ? wsr : {wsr[LW-1:0], wsr[LW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      hsr      <= '0;
      wsr      <= '0;
      osr      <= '0;
      cnt      <= '0;
      ptr      <= '0;
      ld_pipe  <= '0;
      wel      <= 1'b0;
      wr_en    <= 1'b0;
      erase_go <= 1'b0;
      dout     <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      erase_go <= 1'b0;
      ld_pipe  <= {ld_pipe[0], 1'b0};
      if (ld_pipe[1]) begin
        if (wide) osr <= rd_data;
        else osr <= {(ptr[0] ? rd_data[LW-1:0] : rd_data[2*LW-1:LW]), {LW{1'b0}}};
      end
      if (!cs) begin
        st   <= ST_IDLE;
        cnt  <= '0;
        dout <= 1'b0;
      end else if (sk_rise) begin
        case (st)
          ST_IDLE: begin
            if (din) begin
              st  <= ST_HDR;
              cnt <= '0;
            end
          end
          ST_HDR: begin
            hsr <= hdr_full[HW-2:0];
            cnt <= cnt + 1'b1;
            if (hdr_last) begin
              cnt <= '0;
              st  <= ST_HOLD;
              case (code)
                CODE_READ: begin
                  ptr     <= hdr_ptr;
                  ld_pipe <= 2'b01;
                  dout    <= 1'b0;
                  st      <= ST_READ;
                end
                CODE_WRITE: begin
                  ptr <= hdr_ptr;
                  st  <= ST_WDATA;
                end
                CODE_SYS: begin
                  case (sys_sel)
                    SYS_ARM:  wel <= 1'b1;
                    SYS_LOCK: wel <= 1'b0;
                    SYS_FILL: erase_go <= wel;
                    default: ;
                  endcase
                end
                default: ;
              endcase
            end
          end
          ST_WDATA: begin
            wsr <= {wsr[2*LW-2:0], din};
            cnt <= cnt + 1'b1;
            if (dat_last) begin
              wr_en <= wel;
              cnt   <= '0;
              st    <= ST_HOLD;
            end
          end
          ST_READ: begin
            dout <= osr[2*LW-1];
            osr  <= {osr[2*LW-2:0], 1'b0};
            if (dat_last) begin
              cnt     <= '0;
              ptr     <= ptr + (wide ? BA'(2) : BA'(1));
              ld_pipe <= 2'b01;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int MEM_BYTES   = 128,
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORDS      = MEM_BYTES / 2,
  localparam int BA         = $clog2(MEM_BYTES),
  localparam int WA         = BA - 1
) (
  input  logic clk,
  input  logic rst,
  input  logic wide,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);

  logic [3:0] raw_in;
  logic [3:0] syn_in;
  logic       sel_s, sclk_s, sdi_s, wide_s;
  logic       sclk_d;
  logic       sk_rise;

  logic              wel_q;
  logic              wr_en;
  logic [WA-1:0]     wr_addr;
  logic [1:0]        wr_lanes;
  logic [2*LANE_W-1:0] wr_data;
  logic              erase_go;
  logic              erasing;
  logic [WA-1:0]     rd_addr;
  logic [2*LANE_W-1:0] rd_data;

  assign raw_in = {wide, sdi, sclk, sel};

  mw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign {wide_s, sdi_s, sclk_s, sel_s} = syn_in;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else sclk_d <= sclk_s;
  end

  assign sk_rise = sclk_s & ~sclk_d;

  mw_ctrl #(.LW(LANE_W), .BA(BA)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cs       (sel_s),
    .sk_rise  (sk_rise),
    .din      (sdi_s),
    .wide     (wide_s),
    .wel      (wel_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_lanes (wr_lanes),
    .wr_data  (wr_data),
    .erase_go (erase_go),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .dout     (sdo)
  );

  mw_store #(.WORDS(WORDS), .LW(LANE_W)) i_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_lanes (wr_lanes),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .erase_go (erase_go),
    .erasing  (erasing)
  );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic sel_s,
  input logic sk_rise,
  input logic sdo,
  input logic wr_en,
  input logic erase_go,
  input logic erasing,
  input logic wel_q
);

  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> (sdo == 1'b0)); // R11

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sel_s && !sk_rise) |=> $stable(sdo)); // R4

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wel_q); // R10

  AST_ERASE_GATED: assert property (@(posedge clk) disable iff (rst)
    erase_go |-> wel_q); // R9

  AST_LATCH_RESET: assert property (@(posedge clk)
    rst |=> !wel_q); // R1

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, erase_go, erasing && wr_en})); // R7

endmodule

bind mw_eeprom mw_eeprom_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_s    (sel_s),
  .sk_rise  (sk_rise),
  .sdo      (sdo),
  .wr_en    (wr_en),
  .erase_go (erase_go),
  .erasing  (erasing),
  .wel_q    (wel_q)
);

// File: tb/test_mw_eeprom.sv
`timescale 1ns/1ps
module test_mw_eeprom;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide = 1'b0;
  logic sel = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;

  int n_chk = 0;
  int n_fail = 0;
  int req = 0;
  int done = 0;
  bit   exp_q[$];
  string tag_q[$];
  logic [7:0] shadow [128];
  bit wel_m = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom i_mw_eeprom (
    .clk  (clk),
    .rst  (rst),
    .wide (wide),
    .sel  (sel),
    .sclk (sclk),
    .sdi  (sdi),
    .sdo  (sdo)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sdo=%0b expected %0b", tag, act, exp);
    end
  endtask

  // scoreboard driver side: push expectation, wait until monitor consumed it
  task automatic expect_bit(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req++;
    wait (done == req);
  endtask

  // monitor: pops expectations and compares against the port
  initial begin
    forever begin
      wait (req > done);
      begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_val(sdo, e, t);
      end
      done++;
    end
  end

  task automatic sk_bit(input bit b);
    sdi = b;
    sclk = 1'b0;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
  endtask

  task automatic cs_on();
    sclk = 1'b0;
    sel = 1'b1;
    tick(4);
  endtask

  task automatic cs_off();
    sclk = 1'b0;
    sdi = 1'b0;
    sel = 1'b0;
    tick(80);
  endtask

  task automatic hdr(input logic [1:0] code, input logic [6:0] addr, input int lead);
    int nb;
    nb = wide ? 6 : 7;
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    sk_bit(1'b1);
    sk_bit(code[1]);
    sk_bit(code[0]);
    for (int i = nb - 1; i >= 0; i--) sk_bit(addr[i]);
  endtask

  task automatic do_read(input logic [6:0] addr, input int nbytes, input int lead, input string tag);
    int start;
    start = wide ? 2 * int'(addr[5:0]) : int'(addr);
    cs_on();
    hdr(2'b10, addr, lead);
    expect_bit(1'b0, {tag, " dummy"});
    for (int k = 0; k < nbytes * 8; k++) begin
      sk_bit(1'b0);
      expect_bit(shadow[(start + k / 8) % 128][7 - k % 8], tag);
    end
    cs_off();
  endtask

  task automatic do_write(input logic [6:0] addr, input logic [15:0] data);
    int nb;
    nb = wide ? 16 : 8;
    cs_on();
    hdr(2'b01, addr, 0);
    for (int i = nb - 1; i >= 0; i--) sk_bit(data[i]);
    cs_off();
    if (wel_m) begin
      if (wide) begin
        shadow[2 * int'(addr[5:0])]     = data[15:8];
        shadow[2 * int'(addr[5:0]) + 1] = data[7:0];
      end else begin
        shadow[int'(addr)] = data[7:0];
      end
    end
  endtask

  task automatic do_sys(input logic [1:0] upper);
    logic [6:0] a;
    a = wide ? {1'b0, upper, 4'b0} : {upper, 5'b0};
    cs_on();
    hdr(2'b00, a, 0);
    cs_off();
    case (upper)
      2'b11: wel_m = 1'b1;
      2'b00: wel_m = 1'b0;
      2'b10: if (wel_m) for (int i = 0; i < 128; i++) shadow[i] = 8'hFF;
      default: ;
    endcase
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(4);
    wel_m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 8'hFF;
    do_reset();
    check_val(sdo, 1'b0, "R1 reset sdo");

    // R8 arm, R9 erase, check all ones
    do_sys(2'b11);
    do_sys(2'b10);
    do_read(7'd0, 4, 0, "R9 erase");

    // R10: write after disarm ignored
    do_sys(2'b00);
    do_write(7'd3, 16'h0012);
    do_read(7'd3, 1, 0, "R10 locked write");

    // R1: latch cleared by reset
    do_sys(2'b11);
    do_reset();
    do_write(7'd9, 16'h0000);
    do_read(7'd9, 1, 0, "R1 write after reset");

    // R7 byte writes, R2 leading zeros, R5 wrap
    do_sys(2'b11);
    do_write(7'd0, 16'h00A5);
    do_write(7'd1, 16'h003C);
    do_write(7'd127, 16'h0081);
    do_read(7'd127, 3, 3, "R2 R5 wrap bytes");

    // R3 word organisation, R7 word write, R4 word read
    wide = 1'b1;
    tick(8);
    do_write(7'd10, 16'hC35A);
    do_read(7'd10, 2, 0, "R3 R4 word read");
    do_read(7'd63, 4, 0, "R5 word wrap");

    // R6 byte view of the word
    wide = 1'b0;
    tick(8);
    do_read(7'd20, 2, 0, "R6 layout");

    // R11 aborted write
    cs_on();
    hdr(2'b01, 7'd40, 0);
    for (int i = 0; i < 4; i++) sk_bit(1'b0);
    cs_off();
    do_read(7'd40, 1, 0, "R11 aborted write");

    // R11 aborted read returns sdo to 0
    cs_on();
    hdr(2'b10, 7'd40, 0);
    expect_bit(1'b0, "R11 dummy");
    sk_bit(1'b0);
    expect_bit(shadow[40][7], "R11 first bit");
    sel = 1'b0;
    tick(8);
    check_val(sdo, 1'b0, "R11 sdo after abort");
    cs_off();

    // R12 reserved codes ignored while armed
    cs_on();
    hdr(2'b11, 7'd0, 0);
    for (int i = 0; i < 8; i++) sk_bit(1'b0);
    cs_off();
    do_sys(2'b01);
    do_read(7'd0, 2, 0, "R12 reserved");
    do_write(7'd50, 16'h0066);
    do_read(7'd50, 1, 0, "R12 latch kept");

    // R10 erase while locked
    do_sys(2'b00);
    do_sys(2'b10);
    do_read(7'd0, 2, 0, "R10 locked erase");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule